// File: doc/BRIEF.md
# PCIe Root Port Power-Up Reset Sequencer

This block walks a PCIe root port out of reset after a start pulse. It first pulls the slot fundamental reset low and then the controller fundamental reset low. It then switches slot power on and keeps both resets asserted for a programmable number of clock cycles. At 100 MHz, 100 ms is 10,000,000 cycles. After the hold it releases the controller reset and then the slot reset. The block then enables the auxiliary clock, sets the PHY hold strobe, which keeps the link training state machine in reset, and releases the power-up reset.

Next the block hands over to an external PHY configuration step through a start/done handshake, and waits there for as long as that step takes. When the step finishes, the block gates the auxiliary clock off, clears the PHY hold, enables the auxiliary clock again and drives the device-type output to the root-complex code. A shutdown input can arrive at any time. It pulls both fundamental resets low on the same edge and abandons the sequence, so that a later boot stage finds the link down.

Top module: `pcie_pwrup_seq`

## Requirements
- R1: After reset every output is low: both fundamental resets and the power-up reset asserted (low), slot power, auxiliary clock, PHY hold, cfg_start, done and busy all 0, and dev_type 0.
- R2: A start pulse sampled while not busy drives slot_rst_n low and busy high on that edge, and drives ctrl_rst_n low on the following edge. The same start edge also clears slot_pwr_en, aux_clk_en, phy_hold and pwrup_rst_n.
- R3: slot_pwr_en rises one edge after ctrl_rst_n falls. ctrl_rst_n rises exactly HOLD_CYC edges after slot_pwr_en rises, and slot_rst_n stays low throughout that time.
- R4: slot_rst_n is released one edge after ctrl_rst_n is released, never before it.
- R5: On the next three edges, in this order, aux_clk_en rises, then phy_hold rises, then pwrup_rst_n and cfg_start rise together. cfg_start stays high until cfg_done is sampled high.
- R6: phy_hold is high whenever pwrup_rst_n rises and throughout the time cfg_start is high.
- R7: On the edge that samples cfg_done, cfg_start and aux_clk_en drop. phy_hold clears on the next edge, and aux_clk_en rises again on the edge after that.
- R8: One edge later dev_type takes the value 4 (root complex), done rises and busy falls. done is only ever high together with dev_type equal to 4.
- R9: shutdown forces slot_rst_n and ctrl_rst_n low on the next edge, together with busy, done and cfg_start. It takes priority over start.
- R10: A start pulse while busy is ignored, and the sequence continues unchanged.
- R11: A start after done reruns the whole sequence. Both resets are asserted again with the slot reset first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up sequence |
| shutdown | input | 1 | Re-assert both fundamental resets and abort |
| cfg_done | input | 1 | External PHY configuration finished |
| slot_rst_n | output | 1 | Slot fundamental reset, active low |
| ctrl_rst_n | output | 1 | Controller fundamental reset, active low |
| slot_pwr_en | output | 1 | Slot power enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| phy_hold | output | 1 | Hold PHY/link training in reset |
| pwrup_rst_n | output | 1 | Controller power-up reset, active low |
| cfg_start | output | 1 | Request PHY configuration |
| dev_type | output | DT_W | Device type code, 4 = root complex |
| done | output | 1 | Sequence complete |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions check the orderings on every cycle:
- the slot reset is low whenever the controller reset falls;
- the controller reset is released before the slot reset;
- the PHY hold is high when the power-up reset rises and while configuration runs;
- the auxiliary clock is off when the hold clears;
- after shutdown both resets are asserted.

Only the bench scenarios can show cycle-exact spacing, such as the length of the hold window. They also show that the sequence waits through configuration delays of random length, that start is ignored mid-sequence, and that a rerun after completion repeats the full sequence.

// File: rtl/pcie_pwrup_seq.sv
module pcie_pwrup_seq #(
  parameter int HOLD_CYC = 10_000_000,
  parameter int DT_W     = 4,
  parameter int DEV_RC   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            shutdown,
  input  logic            cfg_done,
  output logic            slot_rst_n,
  output logic            ctrl_rst_n,
  output logic            slot_pwr_en,
  output logic            aux_clk_en,
  output logic            phy_hold,
  output logic            pwrup_rst_n,
  output logic            cfg_start,
  output logic [DT_W-1:0] dev_type,
  output logic            done,
  output logic            busy
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_PWR, S_HOLD, S_RELS, S_AUX, S_PHY,
    S_PUR, S_CFG, S_CLR, S_AUX2, S_DT
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      slot_rst_n  <= 1'b0;
      ctrl_rst_n  <= 1'b0;
      slot_pwr_en <= 1'b0;
      aux_clk_en  <= 1'b0;
      phy_hold    <= 1'b0;
      pwrup_rst_n <= 1'b0;
      cfg_start   <= 1'b0;
      dev_type    <= '0;
      done        <= 1'b0;
      busy        <= 1'b0;
    end else if (shutdown) begin
      st         <= S_IDLE;
      slot_rst_n <= 1'b0;
      ctrl_rst_n <= 1'b0;
      cfg_start  <= 1'b0;
      done       <= 1'b0;
      busy       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          slot_rst_n  <= 1'b0;
          slot_pwr_en <= 1'b0;
          aux_clk_en  <= 1'b0;
          phy_hold    <= 1'b0;
          pwrup_rst_n <= 1'b0;
          done        <= 1'b0;
          busy        <= 1'b1;
          st          <= S_CTRL;
        end
        S_CTRL: begin ctrl_rst_n <= 1'b0; st <= S_PWR; end
        S_PWR:  begin slot_pwr_en <= 1'b1; cnt <= '0; st <= S_HOLD; end
        S_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            ctrl_rst_n <= 1'b1;
            st         <= S_RELS;
          end
        end
        S_RELS: begin slot_rst_n <= 1'b1; st <= S_AUX; end
        S_AUX:  begin aux_clk_en <= 1'b1; st <= S_PHY; end
        S_PHY:  begin phy_hold <= 1'b1; st <= S_PUR; end
        S_PUR:  begin pwrup_rst_n <= 1'b1; cfg_start <= 1'b1; st <= S_CFG; end
        S_CFG:  if (cfg_done) begin
          cfg_start  <= 1'b0;
          aux_clk_en <= 1'b0;
          st         <= S_CLR;
        end
        S_CLR:  begin phy_hold <= 1'b0; st <= S_AUX2; end
        S_AUX2: begin aux_clk_en <= 1'b1; st <= S_DT; end
        S_DT: begin
          dev_type <= DT_W'(DEV_RC);
          done     <= 1'b1;
          busy     <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst_n) |-> !slot_rst_n); // R2
  AST_PWR_AT_CTRL_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n) |-> slot_pwr_en && !slot_rst_n); // R3
  AST_CTRL_BEFORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n) |-> ctrl_rst_n); // R4
  AST_CFG_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |-> phy_hold && pwrup_rst_n && busy); // R5
  AST_HOLD_BEFORE_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrup_rst_n) |-> phy_hold); // R6
  AST_AUX_OFF_AT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_hold) && busy |-> !aux_clk_en); // R7
  AST_DONE_RC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dev_type == DT_W'(DEV_RC) && !busy); // R8
  AST_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !slot_rst_n && !ctrl_rst_n && !busy && !done); // R9
endmodule

// File: tb/test_pcie_pwrup_seq.sv
module test_pcie_pwrup_seq;
  localparam int HOLD = 12;
  localparam int PA = 1, PB = 2, PC = 3, PD = 4, PE = 5, PF = 6, PG = 7,
                 PH = 8, PI = 9, PJ = 10, PK = 11, PL = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, shutdown = 1'b0, cfg_done = 1'b0;
  logic slot_rst_n, ctrl_rst_n, slot_pwr_en, aux_clk_en, phy_hold, pwrup_rst_n;
  logic cfg_start, done, busy;
  logic [3:0] dev_type;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pcie_pwrup_seq #(.HOLD_CYC(HOLD), .DT_W(4), .DEV_RC(4)) i_pcie_pwrup_seq (
    .clk, .rst_n, .start, .shutdown, .cfg_done, .slot_rst_n, .ctrl_rst_n,
    .slot_pwr_en, .aux_clk_en, .phy_hold, .pwrup_rst_n, .cfg_start,
    .dev_type, .done, .busy);

  function automatic logic [8:0] exp_vec(int p, logic cw);
    logic s, c, pw, a, h, pu, cs, d, b;
    s  = p >= PE;
    c  = (p == PA) ? cw : (p >= PD);
    pw = p >= PC;
    a  = (p >= PF && p < PI) || p >= PK;
    h  = p >= PG && p < PJ;
    pu = p >= PH;
    cs = p == PH;
    d  = p == PL;
    b  = p >= PA && p != PL;
    return {s, c, pw, a, h, pu, cs, d, b};
  endfunction

  function automatic logic [8:0] act_vec();
    return {slot_rst_n, ctrl_rst_n, slot_pwr_en, aux_clk_en, phy_hold,
            pwrup_rst_n, cfg_start, done, busy};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_seq(int wait_cyc, bit poke);
    logic cw;
    cw = ctrl_rst_n;
    start = 1'b1; step(); start = 1'b0;
    chk("R2 slot reset first", act_vec(), exp_vec(PA, cw));
    step(); chk("R2 ctrl reset second", act_vec(), exp_vec(PB, cw));
    for (int i = 0; i < HOLD; i++) begin
      step(); chk("R3 hold window", act_vec(), exp_vec(PC, cw));
    end
    step(); chk("R3 ctrl release after hold", act_vec(), exp_vec(PD, cw));
    step(); chk("R4 slot release", act_vec(), exp_vec(PE, cw));
    step(); chk("R5 aux on", act_vec(), exp_vec(PF, cw));
    step(); chk("R5 phy hold on", act_vec(), exp_vec(PG, cw));
    step(); chk("R6 pwrup release under hold", act_vec(), exp_vec(PH, cw));
    if (poke) begin
      start = 1'b1; step(); start = 1'b0;
      chk("R10 start ignored while busy", act_vec(), exp_vec(PH, cw));
    end
    for (int i = 0; i < wait_cyc; i++) begin
      step(); chk("R5 wait for cfg_done", act_vec(), exp_vec(PH, cw));
    end
    cfg_done = 1'b1; step(); cfg_done = 1'b0;
    chk("R7 aux gated", act_vec(), exp_vec(PI, cw));
    step(); chk("R7 hold cleared", act_vec(), exp_vec(PJ, cw));
    step(); chk("R7 aux regated on", act_vec(), exp_vec(PK, cw));
    step(); chk("R8 done", act_vec(), exp_vec(PL, cw));
    chk("R8 device type", 32'(dev_type), 32'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) step();
    chk("R1 reset state", act_vec(), 9'b0);
    chk("R1 dev_type reset", 32'(dev_type), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", act_vec(), 9'b0);

    run_seq(0, 1'b0);
    run_seq(5, 1'b1);   // R11 rerun after done

    // R9 shutdown during hold window
    start = 1'b1; step(); start = 1'b0;
    repeat (5) step();
    shutdown = 1'b1; step(); shutdown = 1'b0;
    chk("R9 shutdown in hold", 32'({slot_rst_n, ctrl_rst_n, busy, done, cfg_start}), 32'd0);
    step();
    chk("R9 stays idle", 32'(busy), 32'd0);

    // R9 shutdown during config wait
    start = 1'b1; step(); start = 1'b0;
    repeat (HOLD + 7) step();
    chk("R5 cfg_start up before shutdown", 32'(cfg_start), 32'd1);
    shutdown = 1'b1; step(); shutdown = 1'b0;
    chk("R9 shutdown in cfg", 32'({slot_rst_n, ctrl_rst_n, busy, done, cfg_start}), 32'd0);

    // R9 priority over start
    start = 1'b1; shutdown = 1'b1; step(); start = 1'b0; shutdown = 1'b0;
    chk("R9 shutdown beats start", 32'(busy), 32'd0);
    step();
    chk("R9 no sequence after tie", 32'(busy), 32'd0);

    for (int r = 0; r < 6; r++) begin
      run_seq(int'($urandom_range(20, 0)), 1'($urandom_range(1, 0)));
      repeat ($urandom_range(3, 0)) step();
      chk("R8 done held in idle", 32'({done, busy}), 32'b10);
    end

    // R9 shutdown after completion
    shutdown = 1'b1; step(); shutdown = 1'b0;
    chk("R9 shutdown after done", 32'({slot_rst_n, ctrl_rst_n, done}), 32'd0);
    run_seq(2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule